// File: doc/BRIEF.md
# Codec Serial Frame Controller

This block produces the frame timing and the serial data path for a sampled audio codec link. A counter runs on the master clock and starts a new sample period every `NOM_PERIOD` clocks. Each period begins with a one-clock active-low frame sync. On the sixteen clocks that follow, a 16-bit converter word is shifted out MSB first while a 16-bit word is shifted in. The upper fourteen bits of the incoming word are a DAC sample and appear on a parallel port. The lowest two bits form a command field that the block decodes itself.

The command field selects one of four actions. Code 00 leaves the period nominal. Code 01 moves the next frame later by the signed value in the adjustment register. Code 10 moves it earlier by that value. Code 11 requests a secondary frame half a nominal period after the primary one, which receives one extra control word. A phase change applies only to the period in which it is decoded, and it never makes that period shorter than `MIN_PERIOD` clocks.

The converter word enters through a valid/ready pair. The block asserts `adc_ready` only in the frame-sync cycle, and the word moves when `adc_valid` is also high. If no word is offered, zeros are sent. The DAC sample leaves through a valid/ready pair. The serial link cannot stall, so back-pressure cannot hold off a frame. A sample that is not accepted stays on the port until the next capture replaces it.

Top module: `codec_frame_ctrl`

## Requirements
- R1: `fs_n` is low for exactly one clock per frame. The first frame sync comes on the first clock after reset is released, and with code 00 primary frames are `NOM_PERIOD` (default 64) clocks apart.
- R2: `adc_ready` is high only in the primary frame-sync cycle. When `adc_valid` is also high in that cycle, `adc_data` is sent MSB first on `sdout` over the next 16 clocks. Otherwise 16 zeros are sent. `sdout` is 0 outside those clocks.
- R3: `sdin` is sampled MSB first over the same 16 clocks. Received bits 15..2 appear on `dac_data`, and `dac_valid` rises on the clock after the 16th bit.
- R4: `dac_valid` and `dac_data` are held until a cycle with `dac_ready` high, and `dac_valid` drops on the next clock. A new capture overwrites an unaccepted sample.
- R5: Command code 01 (bit 1 = 0, bit 0 = 1) makes the current period `NOM_PERIOD` + adj clocks, where adj is the 8-bit two's-complement adjustment value. A negative adj therefore moves the next frame earlier.
- R6: Command code 10 makes the current period `NOM_PERIOD` − adj clocks. A negative adj therefore moves the next frame later.
- R7: An adjusted period is never shorter than `MIN_PERIOD` (default 34) clocks. Shorter results are raised to that value.
- R8: An adjustment affects only the period in which it is decoded. The following period is nominal unless a new command changes it.
- R9: Command code 11 produces exactly one secondary frame sync `NOM_PERIOD`/2 clocks after the primary one, and the primary spacing stays nominal. The 16 bits that follow the secondary sync are captured whole on `sec_word`, and `sec_valid` pulses for one clock after the 16th bit. `sdout` stays 0 during the secondary frame.
- R10: The adjustment register is loaded by `adj_wr_en` and keeps its value between writes. The value it holds when the command is decoded is the one used.
- R11: During reset `fs_n` is 1 and `sdout`, `adc_ready`, `dac_valid`, `sec_valid`, `dac_data` and `sec_word` are 0. The adjustment register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adj_wr_en | input | 1 | Load strobe for the adjustment register |
| adj_wr_data | input | ADJ_W | Signed adjustment value to load |
| adc_valid | input | 1 | Converter word offered |
| adc_data | input | WORD_W | Converter word to send |
| adc_ready | output | 1 | Block takes a converter word this cycle |
| fs_n | output | 1 | Active-low frame sync, primary and secondary |
| sdout | output | 1 | Serial data out |
| sdin | input | 1 | Serial data in |
| dac_valid | output | 1 | Captured DAC sample available |
| dac_ready | input | 1 | Consumer accepts the DAC sample |
| dac_data | output | WORD_W-2 | Captured DAC sample |
| sec_valid | output | 1 | One-clock strobe for a received secondary word |
| sec_word | output | WORD_W | Word received in the secondary frame |

## Verification
The hardest cases are periods at the extremes of the adjustment range. An advance of +127 or a delay of −100 must hit the 34-clock floor, and an advance of −128 stretches the period to 192 clocks. The stimulus reaches these by loading the adjustment register in the frame-sync cycle, just ahead of the word whose command bits use it, and then measuring the clocks to the next sync. A secondary frame needs code 11 followed by a second 16-bit shift that starts mid-period. The stimulus follows the sync pulse to that point and checks that the primary spacing is unchanged. Holding `dac_ready` low across two frames brings out the overwrite rule.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_LATER   = 2'b01,
    CMD_EARLIER = 2'b10,
    CMD_SECOND  = 2'b11
  } cmd_e;
endpackage

// File: rtl/cfc_frame_timer.sv
module cfc_frame_timer #(
  parameter int NOM_PERIOD = 64,
  parameter int MIN_PERIOD = 34,
  parameter int WORD_W     = 16,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_load,
  input  logic [CNT_W-1:0] per_value,
  input  logic             sec_pend,
  output logic             fs_n,
  output logic             pri_start,
  output logic             pri_win,
  output logic             pri_last,
  output logic             sec_win,
  output logic             sec_last
);
  localparam logic [CNT_W-1:0] ONE_C      = CNT_W'(1);
  localparam logic [CNT_W-1:0] NOM_C      = CNT_W'(NOM_PERIOD);
  localparam logic [CNT_W-1:0] MIN_C      = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] HALF_C     = CNT_W'(NOM_PERIOD / 2);
  localparam logic [CNT_W-1:0] LAST_C     = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SEC_LAST_C = CNT_W'(NOM_PERIOD / 2 + WORD_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_period;
  logic             wrap;
  logic             sec_start;

  assign wrap      = (cnt == cur_period - ONE_C);
  assign pri_start = (cnt == '0);
  assign pri_win   = (cnt >= ONE_C) && (cnt <= LAST_C);
  assign pri_last  = (cnt == LAST_C);
  assign sec_start = sec_pend && (cnt == HALF_C);
  assign sec_win   = sec_pend && (cnt > HALF_C) && (cnt <= SEC_LAST_C);
  assign sec_last  = sec_pend && (cnt == SEC_LAST_C);
  assign fs_n      = !(pri_start || sec_start);

  // reset parks the counter on its last count so the first sync follows at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= NOM_C - ONE_C;
      cur_period <= NOM_C;
    end else if (wrap) begin
      cnt        <= '0;
      cur_period <= NOM_C;
    end else begin
      cnt <= cnt + ONE_C;
      if (per_load) cur_period <= per_value;
    end
  end

  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_n |=> fs_n); // R1
  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    cur_period >= MIN_C); // R7
  AST_LOAD_AT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    per_load |-> pri_last); // R5
  AST_PERIOD_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    pri_start |-> cur_period == NOM_C); // R8
endmodule

// File: rtl/cfc_cmd_decoder.sv
module cfc_cmd_decoder
  import cfc_pkg::*;
#(
  parameter int NOM_PERIOD = 64,
  parameter int MIN_PERIOD = 34,
  parameter int ADJ_W      = 8,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adj_wr_en,
  input  logic [ADJ_W-1:0] adj_wr_data,
  input  logic             frame_start,
  input  logic             word_done,
  input  logic [1:0]       ctrl_bits,
  input  logic             sec_done,
  output logic             per_load,
  output logic [CNT_W-1:0] per_value,
  output logic             sec_pend
);
  localparam int CW2 = CNT_W + 2;
  localparam logic signed [CW2-1:0] NOM_S = CW2'(NOM_PERIOD);
  localparam logic signed [CW2-1:0] MIN_S = CW2'(MIN_PERIOD);
  localparam logic [CNT_W-1:0]      MIN_C = CNT_W'(MIN_PERIOD);

  logic [ADJ_W-1:0]        adj_q;
  logic signed [CW2-1:0]   adj_s;
  logic signed [CW2-1:0]   calc;
  cmd_e                    cmd;

  assign cmd   = cmd_e'(ctrl_bits);
  assign adj_s = signed'({{(CW2-ADJ_W){adj_q[ADJ_W-1]}}, adj_q});

  always_comb begin
    if (cmd == CMD_LATER) calc = NOM_S + adj_s;
    else                  calc = NOM_S - adj_s;
    per_value = (calc < MIN_S) ? MIN_C : calc[CNT_W-1:0];
    per_load  = word_done && ((cmd == CMD_LATER) || (cmd == CMD_EARLIER));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adj_q <= '0;
    else if (adj_wr_en) adj_q <= adj_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sec_pend <= 1'b0;
    else if (frame_start)                    sec_pend <= 1'b0;
    else if (word_done && cmd == CMD_SECOND) sec_pend <= 1'b1;
    else if (sec_done)                       sec_pend <= 1'b0;
  end

  AST_SEC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pend |-> !per_load); // R9
  AST_SEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_done |=> !sec_pend); // R9
endmodule

// File: rtl/cfc_serial_lane.sv
module cfc_serial_lane #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_start,
  input  logic              pri_win,
  input  logic              sec_win,
  input  logic              adc_valid,
  input  logic [WORD_W-1:0] adc_data,
  input  logic              sdin,
  output logic              sdout,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sr;
  logic [WORD_W-2:0] rx_sr;

  assign sdout   = pri_win & tx_sr[WORD_W-1];
  assign rx_word = {rx_sr, sdin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_sr <= '0;
    else if (pri_start) tx_sr <= adc_valid ? adc_data : '0;
    else if (pri_win)   tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rx_sr <= '0;
    else if (pri_win || sec_win) rx_sr <= {rx_sr[WORD_W-3:0], sdin};
  end

  AST_TX_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_start && adc_valid) |=> tx_sr == $past(adc_data)); // R2
endmodule

// File: rtl/codec_frame_ctrl.sv
module codec_frame_ctrl #(
  parameter int NOM_PERIOD = 64,
  parameter int MIN_PERIOD = 34,
  parameter int WORD_W     = 16,
  parameter int ADJ_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adj_wr_en,
  input  logic [ADJ_W-1:0]  adj_wr_data,
  input  logic              adc_valid,
  input  logic [WORD_W-1:0] adc_data,
  output logic              adc_ready,
  output logic              fs_n,
  output logic              sdout,
  input  logic              sdin,
  output logic              dac_valid,
  input  logic              dac_ready,
  output logic [WORD_W-3:0] dac_data,
  output logic              sec_valid,
  output logic [WORD_W-1:0] sec_word
);
  localparam int CNT_W = $clog2(NOM_PERIOD + (1 << (ADJ_W - 1)) + 1);

  logic             per_load;
  logic [CNT_W-1:0] per_value;
  logic             sec_pend;
  logic             pri_start, pri_win, pri_last, sec_win, sec_last;
  logic [WORD_W-1:0] rx_word;

  cfc_frame_timer #(
    .NOM_PERIOD(NOM_PERIOD), .MIN_PERIOD(MIN_PERIOD),
    .WORD_W(WORD_W), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .per_load(per_load), .per_value(per_value),
    .sec_pend(sec_pend), .fs_n(fs_n), .pri_start(pri_start), .pri_win(pri_win),
    .pri_last(pri_last), .sec_win(sec_win), .sec_last(sec_last)
  );

  cfc_cmd_decoder #(
    .NOM_PERIOD(NOM_PERIOD), .MIN_PERIOD(MIN_PERIOD),
    .ADJ_W(ADJ_W), .CNT_W(CNT_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .adj_wr_en(adj_wr_en), .adj_wr_data(adj_wr_data),
    .frame_start(pri_start), .word_done(pri_last), .ctrl_bits(rx_word[1:0]),
    .sec_done(sec_last), .per_load(per_load), .per_value(per_value),
    .sec_pend(sec_pend)
  );

  cfc_serial_lane #(.WORD_W(WORD_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .pri_start(pri_start), .pri_win(pri_win),
    .sec_win(sec_win), .adc_valid(adc_valid), .adc_data(adc_data),
    .sdin(sdin), .sdout(sdout), .rx_word(rx_word)
  );

  assign adc_ready = pri_start;

  // captured sample waits for the consumer; a fresh capture always wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_valid <= 1'b0;
      dac_data  <= '0;
    end else if (pri_last) begin
      dac_valid <= 1'b1;
      dac_data  <= rx_word[WORD_W-1:2];
    end else if (dac_valid && dac_ready) begin
      dac_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_valid <= 1'b0;
      sec_word  <= '0;
    end else begin
      sec_valid <= sec_last;
      if (sec_last) sec_word <= rx_word;
    end
  end

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && !dac_ready && !pri_last) |=> (dac_valid && $stable(dac_data))); // R4
  AST_SDOUT_QUIET_FS: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_n |-> !sdout); // R2
  AST_SEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |=> !sec_valid); // R9
endmodule

// File: tb/sim_codec_frame_ctrl.sv
`timescale 1ns/1ps
module sim_codec_frame_ctrl;
  localparam int NOM  = 64;
  localparam int HALF = NOM / 2;
  localparam int MINP = 34;

  typedef struct packed {
    logic [15:0] adc;
    logic [15:0] din;
    logic [7:0]  adj;
    logic        wr;
    logic [15:0] gap;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'hA55A, 16'h48D0, 8'h05, 1'b1, 16'd64},  // code 00 nominal
    '{16'h8001, 16'hFFFD, 8'h0A, 1'b1, 16'd74},  // 01 +10
    '{16'h0000, 16'h0004, 8'h00, 1'b0, 16'd64},  // 00 after adjust
    '{16'h3C3C, 16'h0006, 8'h00, 1'b0, 16'd54},  // 10, reg kept at +10
    '{16'hFFFF, 16'hAAA9, 8'hF6, 1'b1, 16'd54},  // 01 -10
    '{16'h1234, 16'h5556, 8'h0A, 1'b1, 16'd54},  // 10 +10
    '{16'h7E81, 16'h3C3E, 8'hEC, 1'b1, 16'd84},  // 10 -20
    '{16'hC3C3, 16'h03FF, 8'h07, 1'b1, 16'd32},  // 11 secondary
    '{16'h0F0F, 16'hC001, 8'h9C, 1'b1, 16'd34},  // 01 -100 floor
    '{16'hF0F0, 16'h2AF2, 8'h7F, 1'b1, 16'd34},  // 10 +127 floor
    '{16'h5A5A, 16'h8006, 8'h80, 1'b1, 16'd192}, // 10 -128
    '{16'h6666, 16'h0000, 8'h00, 1'b0, 16'd64}   // 00 back to nominal
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adj_wr_en = 1'b0;
  logic [7:0] adj_wr_data = '0;
  logic adc_valid = 1'b0;
  logic [15:0] adc_data = '0;
  logic adc_ready, fs_n, sdout, dac_valid, sec_valid;
  logic sdin = 1'b0;
  logic dac_ready = 1'b1;
  logic [13:0] dac_data;
  logic [15:0] sec_word;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  codec_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .adj_wr_en(adj_wr_en), .adj_wr_data(adj_wr_data),
    .adc_valid(adc_valid), .adc_data(adc_data), .adc_ready(adc_ready),
    .fs_n(fs_n), .sdout(sdout), .sdin(sdin), .dac_valid(dac_valid),
    .dac_ready(dac_ready), .dac_data(dac_data), .sec_valid(sec_valid),
    .sec_word(sec_word)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL R1 watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // entered at the negedge of the sync cycle; leaves at the clock after bit 16
  task automatic prim_frame(input logic [15:0] adc, input logic [15:0] din,
                            input logic [7:0] adj, input logic wr, input logic av,
                            output logic [15:0] tx, output logic r0, output logic r1,
                            output logic v17, output logic [13:0] d17);
    r0 = adc_ready;
    adc_data = adc;
    adc_valid = av;
    adj_wr_data = adj;
    adj_wr_en = wr;
    tx = '0;
    r1 = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 0) begin
        r1 = adc_ready;
        adj_wr_en = 1'b0;
      end
      sdin = din[15-k];
      tx[15-k] = sdout;
    end
    @(negedge clk);
    sdin = 1'b0;
    v17 = dac_valid;
    d17 = dac_data;
  endtask

  task automatic sec_frame(input logic [15:0] w, output logic quiet,
                           output logic sv, output logic [15:0] sw);
    quiet = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      sdin = w[15-k];
      if (sdout !== 1'b0) quiet = 1'b0;
    end
    @(negedge clk);
    sdin = 1'b0;
    sv = sec_valid;
    sw = sec_word;
  endtask

  task automatic gap_to_fs(input int start, output int n);
    n = start;
    while (fs_n !== 1'b0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic string tag_of(input logic [1:0] code, input logic wr,
                                   input logic [15:0] gap);
    if (gap == 16'(MINP)) return "R7";
    if (code == 2'b11) return "R9";
    if (code == 2'b00) return "R8";
    if (!wr) return "R10";
    return (code == 2'b01) ? "R5" : "R6";
  endfunction

  initial begin
    logic [15:0] tx;
    logic r0, r1, v17, quiet, sv;
    logic [13:0] d17;
    logic [15:0] sw;
    int n;

    // R11 reset state
    repeat (4) @(negedge clk);
    chk("R11", "fs_n in reset", 32'(fs_n), 32'd1);
    chk("R11", "sdout/adc_ready/dac_valid/sec_valid in reset",
        {28'd0, sdout, adc_ready, dac_valid, sec_valid}, 32'd0);
    chk("R11", "dac_data/sec_word in reset", {2'b0, dac_data, sec_word}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first sync one clock after reset", 32'(fs_n), 32'd0);

    for (int i = 0; i < NV; i++) begin
      prim_frame(VECS[i].adc, VECS[i].din, VECS[i].adj, VECS[i].wr, 1'b1,
                 tx, r0, r1, v17, d17);
      chk("R2", "serial ADC word", 32'(tx), 32'(VECS[i].adc));
      chk("R3", "dac_valid after 16th bit", 32'(v17), 32'd1);
      chk("R3", "dac_data", 32'(d17), 32'(VECS[i].din[15:2]));
      @(negedge clk);
      chk("R4", "dac_valid drops after accept", 32'(dac_valid), 32'd0);
      gap_to_fs(18, n);
      chk(tag_of(VECS[i].din[1:0], VECS[i].wr, VECS[i].gap), "sync spacing",
          32'(n), 32'(VECS[i].gap));
      if (VECS[i].din[1:0] == 2'b11) begin
        sec_frame(16'hC0DE ^ 16'(i), quiet, sv, sw);
        chk("R9", "sdout quiet in secondary frame", 32'(quiet), 32'd1);
        chk("R9", "sec_valid", 32'(sv), 32'd1);
        chk("R9", "sec_word", 32'(sw), 32'(16'hC0DE ^ 16'(i)));
        @(negedge clk);
        chk("R9", "sec_valid single pulse", 32'(sec_valid), 32'd0);
        gap_to_fs(HALF + 18, n);
        chk("R9", "primary spacing with secondary", 32'(n), 32'(NOM));
      end
    end

    // R2: no word offered -> zeros, ready only in the sync cycle
    prim_frame(16'hFFFF, 16'h1110, 8'h00, 1'b0, 1'b0, tx, r0, r1, v17, d17);
    chk("R2", "zeros when adc_valid low", 32'(tx), 32'd0);
    chk("R2", "adc_ready in sync cycle", 32'(r0), 32'd1);
    chk("R2", "adc_ready after sync cycle", 32'(r1), 32'd0);
    gap_to_fs(17, n);

    // R4: back-pressure holds, new capture overwrites
    dac_ready = 1'b0;
    prim_frame(16'h0001, 16'h4444, 8'h00, 1'b0, 1'b1, tx, r0, r1, v17, d17);
    gap_to_fs(17, n);
    chk("R4", "dac_valid held without ready", 32'(dac_valid), 32'd1);
    chk("R4", "dac_data held without ready", 32'(dac_data), 32'(14'h1111));
    prim_frame(16'h0002, 16'h8888, 8'h00, 1'b0, 1'b1, tx, r0, r1, v17, d17);
    chk("R4", "overwrite valid", 32'(v17), 32'd1);
    chk("R4", "overwrite data", 32'(d17), 32'(14'h2222));
    dac_ready = 1'b1;
    @(negedge clk);
    chk("R4", "drop after late accept", 32'(dac_valid), 32'd0);
    gap_to_fs(18, n);

    // R11 / R10: reset mid-run clears the adjustment register
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "fs_n during mid-run reset", 32'(fs_n), 32'd1);
    chk("R11", "outputs during mid-run reset",
        {28'd0, sdout, adc_ready, dac_valid, sec_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sync after reset release", 32'(fs_n), 32'd0);
    prim_frame(16'h0000, 16'h048D, 8'h00, 1'b0, 1'b1, tx, r0, r1, v17, d17);
    gap_to_fs(17, n);
    chk("R10", "adjust register resets to zero", 32'(n), 32'(NOM));
    chk("R1", "nominal spacing", 32'(n), 32'(NOM));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule